// File: doc/BRIEF.md
# Paired-Entry Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. Each slot holds a virtual page-pair tag and two physical frame numbers. One frame belongs to the even page of an adjacent pair and the other to the odd page. Each frame has its own valid flag, and the slot has a valid flag of its own. A lookup presents a virtual page number and gets back, in the same cycle, a hit flag and the frame for that page. The least significant page bit is left out of the tag compare and picks which of the two frames is returned.

When a lookup misses, the surrounding logic fetches both translations of the pair from memory. It then writes them through the refill port as one complete slot: the tag and both frames with their flags, all in a single cycle. The slot that receives the refill is named by a round-robin pointer. The pointer starts at slot 0 after reset and moves on by one after every refill. Whatever the slot held before is discarded. The new translations are visible to lookups from the cycle after the refill edge, and they stay until that slot comes round again.

Top module: `pair_tlb`

## Requirements
- R1: A synchronous active-high reset clears every slot's valid flag, so every lookup after reset misses until a refill is written.
- R2: A lookup hits when a valid slot's tag equals `lk_vpn[VPN_W-1:1]` and the addressed frame's flag is set. `lk_vpn[0]`=0 returns the even frame and `lk_vpn[0]`=1 returns the odd frame, both in the same cycle.
- R3: On a miss, `lk_hit` is 0 and `lk_pfn` is all zeros.
- R4: If the tag matches but the addressed frame's flag is clear, the lookup is a miss. The other frame of the same slot still hits.
- R5: A refill with `fill_en`=1 at a rising edge writes the tag, both frames and both flags into one slot. Lookups see them from the next cycle on.
- R6: Refills go to slot 0 first after reset, then to each following slot in turn. After slot ENTRIES-1 they wrap to slot 0, so refill ENTRIES+1 evicts the first refill.
- R7: A refill replaces both translations of the chosen slot at once. Neither half of the evicted pair hits afterwards.
- R8: If more than one slot qualifies under R2, the frame comes from the lowest-indexed qualifying slot.
- R9: While `fill_en` is 0, the values on the refill inputs have no effect on any slot or on the replacement pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Translation found and frame valid |
| lk_pfn | output | PFN_W | Physical frame for the addressed page, zero on miss |
| fill_en | input | 1 | Write a complete slot at this edge |
| fill_tag | input | VPN_W-1 | Page-pair tag (page number without its low bit) |
| fill_even_pfn | input | PFN_W | Frame for the even page |
| fill_even_ok | input | 1 | Even frame valid |
| fill_odd_pfn | input | PFN_W | Frame for the odd page |
| fill_odd_ok | input | 1 | Odd frame valid |

## Verification
The bench builds the block with ENTRIES=8, VPN_W=12 and PFN_W=10. Eight slots make the pointer wrap and the eviction of the first refill reachable after only nine refills. The random phase draws tags from a pool of twelve, more than the slot count. That mix makes hits, evictions and duplicate tags in several slots all frequent, which exercises the lowest-index selection and the per-frame valid flags many times.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int unsigned DEF_ENTRIES = 16;
    localparam int unsigned DEF_VPN_W   = 20;
    localparam int unsigned DEF_PFN_W   = 20;

    // Which frame of a page pair a lookup addresses.
    typedef enum logic {
        HALF_EVEN = 1'b0,
        HALF_ODD  = 1'b1
    } half_e;

    function automatic half_e half_of(input logic page_lsb);
        return page_lsb ? HALF_ODD : HALF_EVEN;
    endfunction

    // Next position of a ring of n positions.
    function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/ptlb_rr_ptr.sv
module ptlb_rr_ptr
    import ptlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= PTR_W'(ring_next(32'(ptr), ENTRIES));
        end
    end

endmodule

// File: rtl/ptlb_slot.sv
module ptlb_slot
    import ptlb_pkg::*;
#(
    parameter int unsigned VPN_W = DEF_VPN_W,
    parameter int unsigned PFN_W = DEF_PFN_W,
    localparam int unsigned TAG_W = VPN_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PFN_W-1:0] wr_even_pfn,
    input  logic             wr_even_ok,
    input  logic [PFN_W-1:0] wr_odd_pfn,
    input  logic             wr_odd_ok,
    input  logic [TAG_W-1:0] rd_tag,
    input  half_e            rd_half,
    output logic             hit,
    output logic [PFN_W-1:0] pfn
);

    typedef struct packed {
        logic             live;
        logic [TAG_W-1:0] tag;
        logic [PFN_W-1:0] even_pfn;
        logic             even_ok;
        logic [PFN_W-1:0] odd_pfn;
        logic             odd_ok;
    } slot_t;

    slot_t entry;
    logic  tag_eq;
    logic  half_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry <= '0;
        end else if (wr_en) begin
            entry <= '{live: 1'b1, tag: wr_tag,
                       even_pfn: wr_even_pfn, even_ok: wr_even_ok,
                       odd_pfn: wr_odd_pfn, odd_ok: wr_odd_ok};
        end
    end

    always_comb begin
        tag_eq  = entry.live && (entry.tag == rd_tag);
        half_ok = (rd_half == HALF_ODD) ? entry.odd_ok : entry.even_ok;
        hit     = tag_eq && half_ok;
        pfn     = (rd_half == HALF_ODD) ? entry.odd_pfn : entry.even_pfn;
    end

endmodule

// File: rtl/ptlb_select.sv
module ptlb_select
    import ptlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned PFN_W   = DEF_PFN_W
) (
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic [PFN_W-1:0]   pfn_vec [ENTRIES],
    output logic               hit,
    output logic [PFN_W-1:0]   pfn
);

    // Walk from the top down so the lowest qualifying slot is written last.
    always_comb begin
        hit = 1'b0;
        pfn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit = 1'b1;
                pfn = pfn_vec[i];
            end
        end
    end

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
    import ptlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PFN_W   = DEF_PFN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-2:0] fill_tag,
    input  logic [PFN_W-1:0] fill_even_pfn,
    input  logic             fill_even_ok,
    input  logic [PFN_W-1:0] fill_odd_pfn,
    input  logic             fill_odd_ok
);

    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned TAG_W = VPN_W - 1;

    logic [PTR_W-1:0]   rr_ptr;
    logic [ENTRIES-1:0] slot_we;
    logic [ENTRIES-1:0] slot_hit;
    logic [PFN_W-1:0]   slot_pfn [ENTRIES];
    logic [TAG_W-1:0]   look_tag;
    half_e              look_half;

    assign look_tag  = lk_vpn[VPN_W-1:1];
    assign look_half = half_of(lk_vpn[0]);

    ptlb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk (clk),
        .rst (rst),
        .adv (fill_en),
        .ptr (rr_ptr)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign slot_we[g] = fill_en && (rr_ptr == PTR_W'(g));

        ptlb_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_slot (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (slot_we[g]),
            .wr_tag      (fill_tag),
            .wr_even_pfn (fill_even_pfn),
            .wr_even_ok  (fill_even_ok),
            .wr_odd_pfn  (fill_odd_pfn),
            .wr_odd_ok   (fill_odd_ok),
            .rd_tag      (look_tag),
            .rd_half     (look_half),
            .hit         (slot_hit[g]),
            .pfn         (slot_pfn[g])
        );
    end

    ptlb_select #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_sel (
        .hit_vec (slot_hit),
        .pfn_vec (slot_pfn),
        .hit     (lk_hit),
        .pfn     (lk_pfn)
    );

endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned PFN_W   = 20,
    parameter int unsigned PTR_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_hit,
    input logic [PFN_W-1:0]   lk_pfn,
    input logic               fill_en,
    input logic [PTR_W-1:0]   ptr,
    input logic [ENTRIES-1:0] hit_vec
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pfn == '0));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (($past(ptr) == PTR_W'(ENTRIES - 1)) ? (ptr == '0)
                                                         : (ptr == $past(ptr) + 1'b1)));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_en |=> $stable(ptr));

    // R2
    slot_to_port_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit_vec) |-> lk_hit);

endmodule

bind pair_tlb ptlb_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .lk_hit  (lk_hit),
    .lk_pfn  (lk_pfn),
    .fill_en (fill_en),
    .ptr     (rr_ptr),
    .hit_vec (slot_hit)
);

// File: tb/pair_tlb_bench.sv
module pair_tlb_bench;

    localparam int unsigned ENTRIES = 8;
    localparam int unsigned VPN_W   = 12;
    localparam int unsigned PFN_W   = 10;
    localparam int unsigned TAG_W   = VPN_W - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic             fill_en = 1'b0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic [PFN_W-1:0] fill_even_pfn = '0;
    logic             fill_even_ok = 1'b0;
    logic [PFN_W-1:0] fill_odd_pfn = '0;
    logic             fill_odd_ok = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pair_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_pair_tlb (
        .clk           (clk),
        .rst           (rst),
        .lk_vpn        (lk_vpn),
        .lk_hit        (lk_hit),
        .lk_pfn        (lk_pfn),
        .fill_en       (fill_en),
        .fill_tag      (fill_tag),
        .fill_even_pfn (fill_even_pfn),
        .fill_even_ok  (fill_even_ok),
        .fill_odd_pfn  (fill_odd_pfn),
        .fill_odd_ok   (fill_odd_ok)
    );

    // Reference model built from the requirements
    logic             m_live [ENTRIES];
    logic [TAG_W-1:0] m_tag  [ENTRIES];
    logic [PFN_W-1:0] m_even [ENTRIES];
    logic             m_eok  [ENTRIES];
    logic [PFN_W-1:0] m_odd  [ENTRIES];
    logic             m_ook  [ENTRIES];
    int               m_ptr;

    function automatic logic [PFN_W:0] model_look(input logic [VPN_W-1:0] v);
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_live[i] && m_tag[i] == v[VPN_W-1:1]) begin
                if (v[0] && m_ook[i]) return {1'b1, m_odd[i]};
                if (!v[0] && m_eok[i]) return {1'b1, m_even[i]};
            end
        end
        return '0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        for (int i = 0; i < ENTRIES; i++) m_live[i] = 1'b0;
        m_ptr = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_fill(input logic [TAG_W-1:0] t, input logic [PFN_W-1:0] e,
                           input logic eok, input logic [PFN_W-1:0] o, input logic ook);
        @(negedge clk);
        fill_en = 1'b1;
        fill_tag = t;
        fill_even_pfn = e;
        fill_even_ok = eok;
        fill_odd_pfn = o;
        fill_odd_ok = ook;
        @(posedge clk);
        m_live[m_ptr] = 1'b1;
        m_tag[m_ptr]  = t;
        m_even[m_ptr] = e;
        m_eok[m_ptr]  = eok;
        m_odd[m_ptr]  = o;
        m_ook[m_ptr]  = ook;
        m_ptr = (m_ptr + 1) % ENTRIES;
        #1 fill_en = 1'b0;
    endtask

    task automatic look(input logic [VPN_W-1:0] v, input string req);
        logic [PFN_W:0] exp;
        @(negedge clk);
        lk_vpn = v;
        #2;
        exp = model_look(v);
        n_cmp++;
        if ({lk_hit, lk_pfn} !== exp) begin
            n_bad++;
            $display("FAIL %s vpn=%h actual hit=%0d pfn=%h expected hit=%0d pfn=%h",
                     req, v, lk_hit, lk_pfn, exp[PFN_W], exp[PFN_W-1:0]);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired before the run finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: nothing hits straight after reset
        look(12'h000, "R1");
        look(12'h001, "R1");
        look(12'hABC, "R1");

        // R5 / R2: full pair written, both halves served
        do_fill(11'h055, 10'h111, 1'b1, 10'h222, 1'b1);
        look({11'h055, 1'b0}, "R5");
        look({11'h055, 1'b1}, "R2");

        // R4: odd frame flagged invalid
        do_fill(11'h0AA, 10'h333, 1'b1, 10'h044, 1'b0);
        look({11'h0AA, 1'b1}, "R4");
        look({11'h0AA, 1'b0}, "R4");

        // R3: unknown tag gives zero frame
        look({11'h0AB, 1'b0}, "R3");

        // R8: duplicate tags, lowest slot wins; invalid half skipped
        do_fill(11'h055, 10'h155, 1'b1, 10'h266, 1'b1);
        look({11'h055, 1'b0}, "R8");
        do_fill(11'h0AA, 10'h300, 1'b0, 10'h077, 1'b1);
        look({11'h0AA, 1'b1}, "R8");
        look({11'h0AA, 1'b0}, "R8");

        // R9: refill inputs wiggle with fill_en low
        @(negedge clk);
        fill_tag = 11'h3F0;
        fill_even_pfn = 10'h3FF;
        fill_even_ok = 1'b1;
        fill_odd_pfn = 10'h2AA;
        fill_odd_ok = 1'b1;
        repeat (3) @(posedge clk);
        look({11'h3F0, 1'b0}, "R9");
        look({11'h055, 1'b1}, "R9");
        // R9: pointer untouched, next refill lands in slot 4 and slots 0..3 survive
        do_fill(11'h0C0, 10'h0C1, 1'b1, 10'h0C2, 1'b1);
        look({11'h0C0, 1'b1}, "R9");
        look({11'h055, 1'b0}, "R9");

        // R6 / R7: wrap of the replacement pointer
        do_reset();
        for (int i = 0; i <= ENTRIES; i++) begin
            do_fill(TAG_W'(11'h100 + i), PFN_W'(i * 3 + 1), 1'b1, PFN_W'(i * 5 + 2), 1'b1);
        end
        look({11'h100, 1'b0}, "R6");
        look({11'h100, 1'b1}, "R7");
        look({11'h101, 1'b0}, "R6");
        look({TAG_W'(11'h100 + ENTRIES), 1'b0}, "R7");
        look({TAG_W'(11'h100 + ENTRIES), 1'b1}, "R7");

        // R1: reset wipes the populated buffer
        do_reset();
        look({11'h101, 1'b0}, "R1");
        look({11'h102, 1'b1}, "R1");

        // R2: random mix of refills and lookups
        for (int k = 0; k < 3000; k++) begin
            logic [TAG_W-1:0] t;
            t = TAG_W'(11'h200 + ($urandom % 12));
            if (($urandom % 10) < 3) begin
                do_fill(t, PFN_W'($urandom), (($urandom % 5) != 0),
                        PFN_W'($urandom), (($urandom % 5) != 0));
            end else begin
                look({t, 1'($urandom)}, "R2");
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule